// File: doc/BRIEF.md
# Mode-Gated Factory Test Control Register

This block holds one byte of factory-test controls inside a microcontroller's peripheral register window. Software can change the byte only while the chip runs in its special (test) operating mode. In normal mode the byte is held at zero, so a normal application can never turn on a test feature by accident. Each control bit is also brought out as its own signal for the test logic elsewhere on the chip.

One of the bits is a condition-code output enable. While it is set, the upper five bits of a parallel port carry the live CPU flags instead of the normal port data. A tester can then watch flag results directly, without writing branch-based checking code. The reset value follows the mode in force during reset: a special-mode reset starts with the reset-disable control already set.

Top module: `testctl_reg`

## Requirements
- R1: A write with `bus_wr_i` high, `bus_addr_i` equal to 0x3E and `special_mode_i` high stores `bus_wdata_i` at the next rising edge. From that cycle on, a read of 0x3E returns the stored value on `bus_rdata_o`, without delay.
- R2: A write made while `special_mode_i` is low has no effect. After the mode returns to special, a read of 0x3E returns 0x00.
- R3: While `special_mode_i` is low, `bus_rdata_o` and all seven control outputs are 0 in that same cycle.
- R4: A clock edge with `rst_n` low loads 0x08 (bit 3, the reset-disable control, set) if `special_mode_i` is high, and loads 0x00 if it is low.
- R5: Bit 6 ignores written data and always reads as 0.
- R6: An edge with `special_mode_i` low clears every stored bit. Raising the mode again does not bring back any earlier value.
- R7: While the condition-code output enable (bit 5) reads as 1, `port_o[7:3]` equals `cc_flags_i[4:0]` (H, N, Z, V, C from bit 7 down to bit 3) in the same cycle and follows every change of the flags.
- R8: While bit 5 reads as 0, `port_o[7:3]` equals `port_norm_i[7:3]`. `port_o[2:0]` always equals `port_norm_i[2:0]`.
- R9: Each stored bit drives its own output: bit 7 illegal-opcode test, bit 5 condition-code output, bit 4 clock bypass, bit 3 reset disable, bit 2 forced watchdog mode, bit 1 forced watchdog, bit 0 timer clock test.
- R10: A read of any address other than 0x3E returns 0x00.
- R11: A write to any address other than 0x3E leaves the stored value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| special_mode_i | input | 1 | High while the chip is in special (test) mode |
| bus_addr_i | input | 6 | Register offset in the peripheral window |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| cc_flags_i | input | 5 | CPU flags H, N, Z, V, C (bit 4 down to bit 0) |
| port_norm_i | input | 8 | Normal port output value |
| port_o | output | 8 | Port value after the flag override |
| ilop_test_en_o | output | 1 | Illegal-opcode test enable |
| ccr_out_en_o | output | 1 | Condition-code output enable |
| clk_bypass_o | output | 1 | Clock bypass |
| rst_disable_o | output | 1 | Reset disable |
| cop_force_mode_o | output | 1 | Forced watchdog mode |
| cop_force_o | output | 1 | Forced watchdog |
| tmr_test_o | output | 1 | Timer clock test |

## Verification
The bench compares against its model on every cycle. A wrong stored bit therefore shows up one cycle after the write or mode change that set it, both on the read data of 0x3E and on that bit's own output line. A wrong bit 5 also shows up at once on the port, as flag values where normal data was expected or the other way round. Mode drops, writes in normal mode and resets taken in either mode are all driven, so a stale or badly gated bit is found in the first cycle after the event.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
   localparam int unsigned CTL_W        = 8;
   localparam int unsigned B_ILOP       = 7;
   localparam int unsigned B_SPARE      = 6;
   localparam int unsigned B_CCR_OUT    = 5;
   localparam int unsigned B_CLK_BYP    = 4;
   localparam int unsigned B_RST_DIS    = 3;
   localparam int unsigned B_COP_MODE   = 2;
   localparam int unsigned B_COP_FORCE  = 1;
   localparam int unsigned B_TMR_TEST   = 0;

   typedef logic [CTL_W-1:0] ctl_t;

   localparam ctl_t WR_MASK     = ~(ctl_t'(1) << B_SPARE);
   localparam ctl_t RST_SPECIAL = ctl_t'(1) << B_RST_DIS;
endpackage

// File: rtl/tcr_bus_if.sv
module tcr_bus_if
   import tcr_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter logic [ADDR_W-1:0] OFFSET = 6'h3E
) (
   input  logic              special_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  ctl_t              ctl_q_i,
   output logic              wr_en_o,
   output ctl_t              rdata_o
);
   logic sel;

   always_comb begin
      sel     = (addr_i == OFFSET);
      wr_en_o = sel & wr_i & special_i;
      rdata_o = (sel & special_i) ? ctl_q_i : '0;
   end
endmodule

// File: rtl/tcr_ctl_store.sv
module tcr_ctl_store
   import tcr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic special_i,
   input  logic wr_en_i,
   input  ctl_t wdata_i,
   output ctl_t ctl_q_o
);
   ctl_t ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= special_i ? RST_SPECIAL : '0;
      else if (!special_i)
         ctl_q <= '0;
      else if (wr_en_i)
         ctl_q <= wdata_i & WR_MASK;
   end

   assign ctl_q_o = ctl_q;

   // R4
   reset_value_chk: assert property (@(posedge clk)
      !rst_n |=> ctl_q == ($past(special_i) ? RST_SPECIAL : ctl_t'(0)));

   // R6
   normal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !special_i |=> ctl_q == '0);

   // R5
   spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[B_SPARE] == 1'b0);

   // R1
   write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && special_i) |=> ctl_q == ($past(wdata_i) & WR_MASK));
endmodule

// File: rtl/tcr_port_mux.sv
module tcr_port_mux #(
   parameter int unsigned PORT_W  = 8,
   parameter int unsigned CC_BITS = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ovr_i,
   input  logic [CC_BITS-1:0] flags_i,
   input  logic [PORT_W-1:0]  norm_i,
   output logic [PORT_W-1:0]  port_o
);
   localparam int unsigned LO_W = PORT_W - CC_BITS;

   if (CC_BITS > PORT_W || CC_BITS == 0) begin : g_bad_width
      $error("tcr_port_mux: CC_BITS must be 1..PORT_W");
   end

   for (genvar i = 0; i < PORT_W; i++) begin : g_bit
      if (i >= LO_W) begin : g_ovr
         assign port_o[i] = ovr_i ? flags_i[i - LO_W] : norm_i[i];
      end else begin : g_pass
         assign port_o[i] = norm_i[i];
      end
   end

   // R7
   flags_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_i |-> port_o[PORT_W-1 -: CC_BITS] == flags_i);

   // R8
   norm_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_i |-> port_o == norm_i);
endmodule

// File: rtl/testctl_reg.sv
module testctl_reg
   import tcr_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter logic [ADDR_W-1:0] OFFSET = 6'h3E,
   parameter int unsigned PORT_W = 8,
   parameter int unsigned CC_BITS = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               special_mode_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic               bus_wr_i,
   input  logic [7:0]         bus_wdata_i,
   output logic [7:0]         bus_rdata_o,
   input  logic [CC_BITS-1:0] cc_flags_i,
   input  logic [PORT_W-1:0]  port_norm_i,
   output logic [PORT_W-1:0]  port_o,
   output logic               ilop_test_en_o,
   output logic               ccr_out_en_o,
   output logic               clk_bypass_o,
   output logic               rst_disable_o,
   output logic               cop_force_mode_o,
   output logic               cop_force_o,
   output logic               tmr_test_o
);
   if (CTL_W != 8) begin : g_bad_ctl
      $error("testctl_reg: control byte must be 8 bits");
   end

   ctl_t ctl_q;
   ctl_t ctl_vis;
   logic wr_en;

   tcr_bus_if #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_bus (
      .special_i (special_mode_i),
      .addr_i    (bus_addr_i),
      .wr_i      (bus_wr_i),
      .ctl_q_i   (ctl_q),
      .wr_en_o   (wr_en),
      .rdata_o   (bus_rdata_o)
   );

   tcr_ctl_store u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .special_i (special_mode_i),
      .wr_en_i   (wr_en),
      .wdata_i   (bus_wdata_i),
      .ctl_q_o   (ctl_q)
   );

   assign ctl_vis = ctl_q & {CTL_W{special_mode_i}};

   assign ilop_test_en_o   = ctl_vis[B_ILOP];
   assign ccr_out_en_o     = ctl_vis[B_CCR_OUT];
   assign clk_bypass_o     = ctl_vis[B_CLK_BYP];
   assign rst_disable_o    = ctl_vis[B_RST_DIS];
   assign cop_force_mode_o = ctl_vis[B_COP_MODE];
   assign cop_force_o      = ctl_vis[B_COP_FORCE];
   assign tmr_test_o       = ctl_vis[B_TMR_TEST];

   tcr_port_mux #(.PORT_W(PORT_W), .CC_BITS(CC_BITS)) u_mux (
      .clk     (clk),
      .rst_n   (rst_n),
      .ovr_i   (ccr_out_en_o),
      .flags_i (cc_flags_i),
      .norm_i  (port_norm_i),
      .port_o  (port_o)
   );

   // R3
   normal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !special_mode_i |-> (bus_rdata_o == 8'h00 && !ccr_out_en_o && !rst_disable_o
                           && !ilop_test_en_o && !cop_force_o));

   // R10
   other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i != OFFSET) |-> bus_rdata_o == 8'h00);

   // R11
   other_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && special_mode_i && $past(special_mode_i) && $past(bus_wr_i)
       && $past(bus_addr_i) != OFFSET) |-> $stable(ctl_q));
endmodule

// File: tb/sim_testctl_reg.sv
`timescale 1ns/1ps
module sim_testctl_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sp = 1'b1;
   logic [5:0] addr = 6'h00;
   logic       wr = 1'b0;
   logic [7:0] wd = 8'h00;
   logic [7:0] rd;
   logic [4:0] flags = 5'h00;
   logic [7:0] pn = 8'h00;
   logic [7:0] po;
   logic       o_ilop, o_ccr, o_byp, o_rdis, o_cmode, o_cforce, o_tmr;

   int checks = 0;
   int fails  = 0;
   int model  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   testctl_reg u0 (
      .clk(clk), .rst_n(rst_n), .special_mode_i(sp),
      .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wd), .bus_rdata_o(rd),
      .cc_flags_i(flags), .port_norm_i(pn), .port_o(po),
      .ilop_test_en_o(o_ilop), .ccr_out_en_o(o_ccr), .clk_bypass_o(o_byp),
      .rst_disable_o(o_rdis), .cop_force_mode_o(o_cmode),
      .cop_force_o(o_cforce), .tmr_test_o(o_tmr)
   );

   // behavioural reference of the stored byte
   always @(posedge clk) begin
      if (!rst_n)             model = sp ? 8 : 0;
      else if (!sp)           model = 0;
      else if (wr && addr == 6'h3E) model = wd & 8'hBF;
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int vis;
         int exp_port;
         vis = sp ? model : 0;
         check("R1/R3/R10 rdata", rd, (addr == 6'h3E) ? vis : 0);
         exp_port = ((vis >> 5) & 1) ? {flags, pn[2:0]} : pn;
         check("R7/R8 port", po, exp_port);
         check("R9 bit outputs", {o_ilop, 1'b0, o_ccr, o_byp, o_rdis, o_cmode, o_cforce, o_tmr},
               vis);
      end
   end

   task automatic step(input logic s, input logic w, input logic [5:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      sp = s; wr = w; addr = a; wd = d;
   endtask

   task automatic summary();
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(5.0 * 100000);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      // reset in special mode
      step(1, 0, 6'h3E, 0);
      step(1, 0, 6'h3E, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R4 special reset value", rd, 8'h08);
      check("R4 reset-disable output", o_rdis, 1);
      // write all ones: spare bit reads 0
      step(1, 1, 6'h3E, 8'hFF);
      step(1, 0, 6'h3E, 8'h00);
      @(negedge clk);
      check("R5 spare bit", rd, 8'hBF);
      check("R1 write taken", rd[7], 1);
      // write elsewhere ignored, read elsewhere zero
      step(1, 1, 6'h3D, 8'h00);
      step(1, 0, 6'h3D, 8'h00);
      @(negedge clk);
      check("R10 other read", rd, 0);
      step(1, 0, 6'h3E, 8'h00);
      @(negedge clk);
      check("R11 other write ignored", rd, 8'hBF);
      // condition-code override, flags changing every cycle
      step(1, 1, 6'h3E, 8'h20);
      for (int i = 0; i < 32; i++) begin
         step(1, 0, 6'h3E, 0);
         flags = 5'(i * 7 + 3); pn = 8'(i * 29 + 5);
         @(negedge clk);
         check("R7 flags on port", po[7:3], flags);
         check("R8 low port bits", po[2:0], pn[2:0]);
      end
      step(1, 1, 6'h3E, 8'h1F);
      flags = 5'h15; pn = 8'hA6;
      step(1, 0, 6'h3E, 0);
      @(negedge clk);
      check("R8 normal pass", po, 8'hA6);
      // mode drop: zero at once, then cleared
      step(1, 1, 6'h3E, 8'hA0);
      step(0, 0, 6'h3E, 0);
      @(negedge clk);
      check("R3 normal read", rd, 0);
      check("R3 override released", po, pn);
      step(0, 1, 6'h3E, 8'hFF);
      step(1, 0, 6'h3E, 0);
      @(negedge clk);
      check("R2 normal write ignored", rd, 0);
      check("R6 cleared after mode drop", o_ccr, 0);
      // reset in normal mode
      rst_n = 1'b0;
      step(0, 0, 6'h3E, 0);
      step(0, 0, 6'h3E, 0);
      rst_n = 1'b1;
      step(1, 0, 6'h3E, 0);
      @(negedge clk);
      check("R4 normal reset value", rd, 0);
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         logic s;
         s = ($urandom % 12) != 0;
         if (($urandom % 97) == 0) rst_n = 1'b0; else rst_n = 1'b1;
         flags = 5'($urandom); pn = 8'($urandom);
         step(s, ($urandom % 3) == 0, ($urandom % 4 == 0) ? 6'($urandom) : 6'h3E,
              8'($urandom));
      end
      step(1, 0, 6'h3E, 0);
      @(negedge clk);
      summary();
   end
endmodule